// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block decodes the control inputs of a synchronous burst SRAM on every rising clock edge and carries out the resulting cycle against a behavioural memory array. Each cycle is one of five kinds: sleep, deselect, burst start, burst continue or burst suspend. Every cycle that reaches the array is either a read or a byte-masked write. The block holds the burst address register and its wrapping counter. Its data output is gated by an output enable that acts without the clock.

Two address strobes can start a burst. The processor strobe has the higher priority, but only when the first chip enable is low, and a burst it starts is always a read. The controller strobe starts a read or a write, chosen by the combined write signal. After a start, continue cycles step through a four-word group and suspend cycles stay on the current word. A deselect ends the burst. The data bus is modelled as separate input, output and output-valid ports carrying four bytes.

Top module: `sbsram_ctrl`

## Requirements
- R1: While `zz` is high, `dout_en` is 0, the array is not written and no burst state changes, whatever the other inputs and the clock do.
- R2: A clock edge with `zz` low is a deselect in either of two cases. The first is `adsc_n` low with `ce1_n` high. The second is either strobe qualifying (`adsp_n` low with `ce1_n` low, or `adsc_n` low) while the chip enables fail, that is `ce1_n` high, `ce2` low or `ce3_n` high. A deselect ends the burst and leaves `dout_en` at 0.
- R3: With `ce1_n`=0, `ce2`=1, `ce3_n`=0 and `adsp_n`=0, the edge loads `addr` and starts a read burst, even when `gw_n`, `bwe_n` or `be_n` request a write.
- R4: With `adsp_n`=1, `adsc_n`=0 and the chip enables valid, the edge loads `addr` and starts a burst. The burst is a write when the combined write signal is active and a read otherwise.
- R5: The combined write signal is active when `gw_n`=0, or when `bwe_n`=0 and at least one bit of `be_n` is 0. In every other case it is inactive.
- R6: A continue cycle has both strobes inactive (an `adsp_n` low while `ce1_n` is high counts as inactive) and `adv_n`=0. It steps the burst address and then reads or writes that word, as the combined write signal selects.
- R7: A suspend cycle has the strobe conditions of R6 with `adv_n`=1. It reads or writes the current burst address again.
- R8: Stepping adds 1 to address bits [1:0] modulo 4, starting from the loaded address. Bits above bit 1 stay fixed for the whole burst.
- R9: With `gw_n`=0, a write updates all four bytes. Otherwise it updates only byte lane i (`din[8i+7:8i]`) for each `be_n[i]`=0. Bytes whose lane is not enabled keep their value.
- R10: After a read edge, `dout` shows the word at the burst address. `dout_en` is 1 only while `oe_n` is 0 and `zz` is 0, and it follows `oe_n` without waiting for a clock edge. After a write edge `dout_en` is 0 whatever `oe_n` is.
- R11: After a deselect or a reset, continue and suspend cycles neither read nor write the array until a strobe starts a new burst.
- R12: After reset no burst is active and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| zz | input | 1 | Sleep request, active high |
| ce1_n | input | 1 | First chip enable, active low, also gates the processor strobe |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| be_n | input | 4 | Per-byte write enables, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| addr | input | 8 | External word address |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, zero when not valid |
| dout_en | output | 1 | Read data is being driven |

## Verification
The bench issues a processor-strobe start while every write input is active. A design that lets the write inputs through would overwrite that word, and the next read would return the wrong data. Bursts are started at address offsets 2 and 3 so that they wrap. A counter that carries into the upper address bits, or that restarts at offset 0, would read from a different word. Continue and suspend cycles are issued after a deselect, and writes are issued during sleep. A design that does not close the burst, or that keeps clocking while asleep, would corrupt words the bench reads afterwards. The output enable is toggled between clock edges and held low during writes, which catches an output that is registered or that is not masked during writes.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [2:0] {
    CYC_SLEEP,
    CYC_DESEL,
    CYC_START_RD,
    CYC_START_RW,
    CYC_STEP,
    CYC_STAY
  } cyc_e;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic             zz,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [BYTES-1:0] be_n,
  output cyc_e             cyc,
  output logic [BYTES-1:0] byte_we,
  output logic             wr_any
);
  logic chip_ok;
  logic psel;

  assign chip_ok = !ce1_n && ce2 && !ce3_n;
  // processor strobe only counts when the first enable is active
  assign psel    = !ce1_n && !adsp_n;

  always_comb begin
    if (zz)             cyc = CYC_SLEEP;
    else if (psel)      cyc = chip_ok ? CYC_START_RD : CYC_DESEL;
    else if (!adsc_n)   cyc = chip_ok ? CYC_START_RW : CYC_DESEL;
    else if (!adv_n)    cyc = CYC_STEP;
    else                cyc = CYC_STAY;
  end

  always_comb begin
    if (!gw_n)       byte_we = '1;
    else if (!bwe_n) byte_we = ~be_n;
    else             byte_we = '0;
  end

  assign wr_any = |byte_we;
endmodule

// File: rtl/sbsram_burst_addr.sv
module sbsram_burst_addr
  import sbsram_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic              wr_any,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rd_q,
  output logic              active_q
);
  logic [BURST_BITS-1:0] lo_inc;
  logic [ADDR_W-1:0]     step_addr;
  logic                  acc_en;

  assign lo_inc = addr_q[BURST_BITS-1:0] + BURST_BITS'(1);

  generate
    if (ADDR_W > BURST_BITS) begin : g_hi
      assign step_addr = {addr_q[ADDR_W-1:BURST_BITS], lo_inc};
    end else begin : g_lo
      assign step_addr = lo_inc;
    end
  endgenerate

  always_comb begin
    cyc_addr = addr_q;
    acc_en   = 1'b0;
    acc_wr   = 1'b0;
    unique case (cyc)
      CYC_START_RD: begin cyc_addr = ext_addr; acc_en = 1'b1; end
      CYC_START_RW: begin cyc_addr = ext_addr; acc_en = 1'b1; acc_wr = wr_any; end
      CYC_STEP: begin
        if (active_q) cyc_addr = step_addr;
        acc_en = active_q;
        acc_wr = active_q && wr_any;
      end
      CYC_STAY: begin acc_en = active_q; acc_wr = active_q && wr_any; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      rd_q     <= 1'b0;
      active_q <= 1'b0;
    end else if (cyc != CYC_SLEEP) begin
      addr_q <= cyc_addr;
      rd_q   <= acc_en && !acc_wr;
      if (cyc == CYC_DESEL) active_q <= 1'b0;
      else if (cyc == CYC_START_RD || cyc == CYC_START_RW) active_q <= 1'b1;
    end
  end

  // R1: sleep freezes the burst state
  p_sleep_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_SLEEP) |=> ($stable(addr_q) && $stable(active_q) && $stable(rd_q)));
  // R2: a deselect closes the burst
  p_desel_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_DESEL) |=> (!active_q && !rd_q));
  // R8: upper bits stay put while stepping
  p_hi_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_STEP && active_q) |=>
      (addr_q[ADDR_W-1:BURST_BITS] == $past(addr_q[ADDR_W-1:BURST_BITS])));
  // R7: suspend keeps the address
  p_stay_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_STAY) |=> $stable(addr_q));
  // R11: no array access without an open burst
  p_closed_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && (cyc == CYC_STEP || cyc == CYC_STAY)) |=> !rd_q);
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [BYTES-1:0]        byte_we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [BYTES*BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
      logic [BYTE_W-1:0] lane [DEPTH];
      always_ff @(posedge clk) begin
        if (we && byte_we[b]) lane[waddr] <= wdata[b*BYTE_W +: BYTE_W];
      end
      assign rdata[b*BYTE_W +: BYTE_W] = lane[raddr];
    end
  endgenerate
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BYTES      = 4,
  parameter int BYTE_W     = 8,
  parameter int BURST_LEN  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    zz,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [BYTES-1:0]        be_n,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] din,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int BURST_BITS = $clog2(BURST_LEN);
  localparam int DATA_W     = BYTES * BYTE_W;

  cyc_e              cyc;
  logic [BYTES-1:0]  byte_we;
  logic              wr_any;
  logic [ADDR_W-1:0] cyc_addr;
  logic [ADDR_W-1:0] addr_q;
  logic              mem_we;
  logic              rd_q;
  logic              active_q;
  logic [DATA_W-1:0] rdata;

  sbsram_decode #(.BYTES(BYTES)) u_decode (
    .zz(zz), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .be_n(be_n),
    .cyc(cyc), .byte_we(byte_we), .wr_any(wr_any)
  );

  sbsram_burst_addr #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_burst (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .wr_any(wr_any), .ext_addr(addr),
    .cyc_addr(cyc_addr), .acc_wr(mem_we), .addr_q(addr_q),
    .rd_q(rd_q), .active_q(active_q)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .we(mem_we), .byte_we(byte_we), .waddr(cyc_addr),
    .wdata(din), .raddr(addr_q), .rdata(rdata)
  );

  // output enable acts combinationally; writes leave rd_q low
  assign dout_en = rd_q && !oe_n && !zz;
  assign dout    = dout_en ? rdata : '0;

  // R3: a processor-strobe start never writes
  p_psel_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !ce1_n && !adsp_n) |-> !mem_we);
  // R10: outputs stay off after a write edge
  p_write_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !dout_en);
  // R1: no write while asleep
  p_sleep_nowr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    zz |-> !mem_we);
  // R11: closed burst never writes on continue or suspend
  p_closed_nowr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && adsc_n && (ce1_n || adsp_n)) |-> !mem_we);
endmodule

// File: tb/sbsram_ctrl_bench.sv
`timescale 1ns/1ps
module sbsram_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        zz, ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n;
  logic [3:0]  be_n;
  logic [7:0]  addr;
  logic [31:0] din;
  logic [31:0] dout;
  logic        dout_en;

  always #10 clk = ~clk;

  sbsram_ctrl u_sbsram_ctrl (
    .clk(clk), .rst_n(rst_n), .zz(zz), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .be_n(be_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_mem [256];
  bit          m_known [256];
  int          m_addr;
  bit          m_active, m_rd;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(string tag);
    bit exp_en;
    exp_en = m_rd && !oe_n && !zz;
    checks++;
    if (dout_en !== exp_en) begin
      errors++;
      $display("FAIL %s dout_en actual=%0b expected=%0b", tag, dout_en, exp_en);
    end
    if (exp_en && m_known[m_addr]) begin
      checks++;
      if (dout !== m_mem[m_addr]) begin
        errors++;
        $display("FAIL %s dout actual=%h expected=%h", tag, dout, m_mem[m_addr]);
      end
    end
  endtask

  task automatic idle();
    zz = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; be_n = 4'hF; oe_n = 0;
  endtask

  // behavioural reference, applied at each rising edge
  task automatic model_edge();
    bit ok, ps, anyw;
    logic [3:0] mask;
    if (zz) return;
    ok = !ce1_n && ce2 && !ce3_n;
    ps = !ce1_n && !adsp_n;
    mask = !gw_n ? 4'hF : (!bwe_n ? ~be_n : 4'h0);
    anyw = (mask != 0);
    if (ps || !adsc_n) begin
      if (!ok) begin m_active = 0; m_rd = 0; return; end
      m_addr = addr; m_active = 1;
      if (ps) anyw = 0;
    end else if (!m_active) begin
      m_rd = 0; return;
    end else if (!adv_n) begin
      m_addr = (m_addr & 'hFC) | ((m_addr + 1) & 3);
    end
    if (anyw) begin
      for (int b = 0; b < 4; b++)
        if (mask[b]) m_mem[m_addr][b*8 +: 8] = din[b*8 +: 8];
      if (mask == 4'hF) m_known[m_addr] = 1;
      m_rd = 0;
    end else m_rd = 1;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m_mem[i] = '0; m_known[i] = 0; end
    m_addr = 0; m_active = 0; m_rd = 0;
    idle(); addr = 0; din = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R12");
    rst_n = 1;
    @(negedge clk);
    // R11: suspend and continue straight after reset do nothing
    adv_n = 0; gw_n = 0; din = 32'hDEAD0000; step("R11");
    idle(); adv_n = 1; step("R11");

    // fill words 0..15 with full writes via the controller strobe (R4)
    for (int a = 0; a < 16; a++) begin
      idle(); adsc_n = 0; gw_n = 0; addr = 8'(a); din = 32'h1000_0000 + a * 32'h01010101;
      step("R4");
    end
    // R3: processor strobe with all write inputs active still reads
    idle(); adsp_n = 0; gw_n = 0; bwe_n = 0; be_n = 0; addr = 8'd5; din = 32'hFFFF_FFFF;
    step("R3");
    idle(); adsp_n = 0; addr = 8'd5; step("R3");
    // R4: controller strobe with write inactive reads
    idle(); adsc_n = 0; addr = 8'd7; step("R4");
    // R5/R9: byte enables without bwe_n do not write; with bwe_n write lanes 0 and 2
    idle(); adsc_n = 0; be_n = 4'b1010; addr = 8'd9; din = 32'hAABBCCDD; step("R5");
    idle(); adsc_n = 0; bwe_n = 0; be_n = 4'b1010; addr = 8'd9; din = 32'hAABBCCDD; step("R9");
    idle(); adsp_n = 0; addr = 8'd9; step("R9");
    idle(); adsc_n = 0; bwe_n = 0; be_n = 4'hF; gw_n = 0; addr = 8'd10; din = 32'h5A5A5A5A; step("R5");
    idle(); adsp_n = 0; addr = 8'd10; step("R5");
    // R6/R8: burst from offset 2 wraps 2,3,0,1
    idle(); adsp_n = 0; addr = 8'd6; step("R6");
    for (int k = 0; k < 5; k++) begin idle(); adv_n = 0; step("R8"); end
    // R6: continue with adsp_n low but ce1_n high
    idle(); ce1_n = 1; adsp_n = 0; adv_n = 0; step("R6");
    // R6: write burst from offset 3
    idle(); adsc_n = 0; gw_n = 0; addr = 8'd11; din = 32'h0B0B0B0B; step("R6");
    idle(); adv_n = 0; gw_n = 0; din = 32'h0808_0808; step("R6");
    idle(); adv_n = 0; step("R8");
    // R7: suspend rereads and rewrites the same word
    idle(); step("R7");
    idle(); bwe_n = 0; be_n = 4'b1110; din = 32'h000000EE; step("R7");
    idle(); step("R7");
    // R2: deselect variants, each followed by a closed continue (R11)
    idle(); ce1_n = 1; adsc_n = 0; gw_n = 0; addr = 8'd3; din = 32'h0; step("R2");
    idle(); adv_n = 0; gw_n = 0; din = 32'h0; step("R11");
    idle(); adsp_n = 0; addr = 8'd4; step("R2");
    idle(); adsp_n = 0; ce2 = 0; addr = 8'd4; step("R2");
    idle(); gw_n = 0; step("R11");
    idle(); adsp_n = 0; addr = 8'd4; step("R2");
    idle(); adsc_n = 0; ce3_n = 1; gw_n = 0; addr = 8'd4; step("R2");
    idle(); adsp_n = 0; addr = 8'd4; step("R11");
    // R1: sleep blanks output and ignores a write
    idle(); adsp_n = 0; addr = 8'd2; step("R1");
    idle(); zz = 1; #1 chk("R1");
    adsc_n = 0; gw_n = 0; addr = 8'd2; din = 32'h77777777; step("R1");
    adv_n = 0; step("R1");
    idle(); #1 chk("R1");
    idle(); adv_n = 1; step("R1");
    // R10: asynchronous output enable, masked on write
    idle(); adsp_n = 0; addr = 8'd12; step("R10");
    oe_n = 1; #2 chk("R10");
    oe_n = 0; #2 chk("R10");
    idle(); gw_n = 0; din = 32'h12345678; step("R10");
    oe_n = 1; #2 chk("R10");
    oe_n = 0; #2 chk("R10");
    // random mix over the filled words
    for (int n = 0; n < 600; n++) begin
      int r;
      idle();
      r = $urandom_range(0, 99);
      zz = (r < 4);
      ce1_n = ($urandom_range(0, 9) == 0); ce2 = ($urandom_range(0, 9) != 0);
      ce3_n = ($urandom_range(0, 9) == 0);
      adsp_n = ($urandom_range(0, 4) != 0); adsc_n = ($urandom_range(0, 4) != 0);
      adv_n = $urandom_range(0, 1); gw_n = ($urandom_range(0, 5) != 0);
      bwe_n = $urandom_range(0, 1); be_n = 4'($urandom_range(0, 15));
      oe_n = ($urandom_range(0, 5) == 0);
      addr = 8'($urandom_range(0, 15)); din = $urandom;
      step("R10");
    end
    finish_run();
  end
endmodule